// File: doc/BRIEF.md
# Guest Address-Space Tag Allocator

This block assigns address-space tags to virtual CPUs each time one of them enters a guest, so that cached translations belonging to different guests never mix. Every request carries the tag and the generation number that the virtual CPU stored after its previous entry. The block answers with the tag to run under, the generation to store for next time, and a flush-control code for the translation cache. A tag the block issued under the current generation is reused without a flush. A missing, out-of-range or stale tag is replaced with the next free one. When the free tags run out, the block opens a new generation and asks for the tag's cached entries to be flushed.

Tag 0 is kept for the host and is never issued. The number of tags, host tag included, is presented on a configuration input and captured while reset is held. If the count leaves no guest tags, every request is answered with an error flag. Requests are accepted with a valid/ready pair. Each accepted request is answered on the following cycle.

Top module: `guest_tag_alloc`

## Requirements
- R1: A response without the error flag never carries tag 0, and its tag lies between 1 and the current largest tag.
- R2: The largest tag is the configuration count minus one, captured on every clock while rstN is low. A count above 2^TAG_W is clamped to 2^TAG_W-1.
- R3: If the stored generation equals the current generation and the stored tag lies in 1..largest tag, the response returns the same tag and generation with flush code 0 (no action). The allocation counter is left unchanged.
- R4: Any other request with guest tags available receives a fresh tag with flush code 0 and the current generation. After reset the fresh tags are issued in increasing order starting at 1.
- R5: A fresh request that arrives after the largest tag has been issued increments the generation and receives tag 1 with flush code 1 (flush all entries of that tag). The next fresh request in that generation receives tag 2.
- R6: The generation is 1 after reset and is never 0. When it wraps, it goes from its all-ones value to 1, so a stored generation of 0 always obtains a fresh tag.
- R7: With a configuration count of 0 or 1, every response has the error flag set, tag 0, flush code 0 and the current generation.
- R8: reqReady is low while rstN is low and high from the first clock after reset is released. An accepted request produces rspValid high on the next cycle only. rspValid is low in every cycle that does not follow an accepted request.
- R9: The flush-control encodings are 0 for no action, 1 for all entries of the tag, 3 for non-global entries of the tag and 7 for this logical CPU only. The block emits only 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfgTagCount | input | TAG_W+1 | Number of tags, host tag included |
| reqValid | input | 1 | Entry request present |
| reqReady | output | 1 | Block accepts requests |
| reqTag | input | TAG_W | Tag stored by the virtual CPU |
| reqGen | input | GEN_W | Generation stored by the virtual CPU |
| rspValid | output | 1 | Response present, one cycle after acceptance |
| rspTag | output | TAG_W | Tag to use for this entry |
| rspGen | output | GEN_W | Generation to store |
| rspFlush | output | 3 | Flush-control code |
| rspErr | output | 1 | No guest tags configured |

## Verification
The generation wrap is the hardest case to reach. The generation only moves when the tag pool is exhausted, so at the full default pool every step costs hundreds of requests. The bench therefore resets with a count of 2, which leaves a single guest tag. Every further request carrying generation 0 then forces a rollover, and about 255 back-to-back requests take the generation through its all-ones value and back to 1. The clamp path is reached by a count above the tag range, followed by a sweep that issues every tag once before the rollover.

// File: rtl/guest_tag_pkg.sv
package guest_tag_pkg;

  typedef enum logic [2:0] {
    FLUSH_NONE          = 3'd0,
    FLUSH_TAG_ALL       = 3'd1,
    FLUSH_TAG_NONGLOBAL = 3'd3,
    FLUSH_LOCAL_CPU     = 3'd7
  } flush_e;

  // decision strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic err;
    logic keep;
    logic fresh;
    logic roll;
  } alloc_strobe_t;

endpackage

// File: rtl/guest_tag_ctrl.sv
module guest_tag_ctrl
  import guest_tag_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int GEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [GEN_W-1:0] reqGen,
  input  logic [TAG_W-1:0] maxTag,
  input  logic [TAG_W:0]   nextTag,
  input  logic [GEN_W-1:0] curGen,
  output logic             reqReady,
  output alloc_strobe_t    strobe
);

  logic readyQ;
  logic noTags;
  logic tagInRange;
  logic genMatch;
  logic poolSpent;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign reqReady = readyQ;

  always_comb begin
    noTags       = (maxTag == '0);
    tagInRange   = (reqTag != '0) && (reqTag <= maxTag);
    genMatch     = (reqGen == curGen);
    poolSpent    = (nextTag > {1'b0, maxTag});
    strobe.accept = reqValid && readyQ;
    strobe.err    = strobe.accept && noTags;
    strobe.keep   = strobe.accept && !noTags && genMatch && tagInRange;
    strobe.fresh  = strobe.accept && !noTags && !(genMatch && tagInRange);
    strobe.roll   = strobe.fresh && poolSpent;
  end

  // R3 R4 R7: exactly one outcome per accepted request
  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |-> $countones({strobe.err, strobe.keep, strobe.fresh}) == 1);

  // R8: nothing decided without acceptance
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accept |-> $onehot0({strobe.err, strobe.keep, strobe.fresh}) &&
                       !strobe.err && !strobe.keep && !strobe.fresh);

endmodule

// File: rtl/guest_tag_dp.sv
module guest_tag_dp
  import guest_tag_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int GEN_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TAG_W:0]     cfgTagCount,
  input  logic [TAG_W-1:0]   reqTag,
  input  alloc_strobe_t      strobe,
  output logic [TAG_W-1:0]   maxTag,
  output logic [TAG_W:0]     nextTag,
  output logic [GEN_W-1:0]   curGen,
  output logic               rspValid,
  output logic [TAG_W-1:0]   rspTag,
  output logic [GEN_W-1:0]   rspGen,
  output flush_e             rspFlush,
  output logic               rspErr
);

  localparam logic [TAG_W:0]   FIRST_TAG  = {{TAG_W{1'b0}}, 1'b1};
  localparam logic [TAG_W:0]   SECOND_TAG = FIRST_TAG + FIRST_TAG;
  localparam logic [GEN_W-1:0] FIRST_GEN  = {{(GEN_W-1){1'b0}}, 1'b1};

  logic [TAG_W:0]   countMinus1;
  logic [TAG_W-1:0] maxTagCfg;
  logic [GEN_W-1:0] genInc;
  logic [GEN_W-1:0] genNext;

  always_comb begin
    countMinus1 = cfgTagCount - FIRST_TAG;
    if (cfgTagCount == '0)       maxTagCfg = '0;
    else if (countMinus1[TAG_W]) maxTagCfg = '1;
    else                         maxTagCfg = countMinus1[TAG_W-1:0];
    genInc  = curGen + FIRST_GEN;
    genNext = (genInc == '0) ? FIRST_GEN : genInc;
  end

  // allocation state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxTag  <= maxTagCfg;
      nextTag <= FIRST_TAG;
      curGen  <= FIRST_GEN;
    end else if (strobe.roll) begin
      nextTag <= SECOND_TAG;
      curGen  <= genNext;
    end else if (strobe.fresh) begin
      nextTag <= nextTag + FIRST_TAG;
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTag   <= '0;
      rspGen   <= '0;
      rspFlush <= FLUSH_NONE;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= strobe.accept;
      if (strobe.accept) begin
        rspErr   <= strobe.err;
        rspFlush <= strobe.roll ? FLUSH_TAG_ALL : FLUSH_NONE;
        rspGen   <= strobe.roll ? genNext : curGen;
        if (strobe.err)        rspTag <= '0;
        else if (strobe.keep)  rspTag <= reqTag;
        else if (strobe.roll)  rspTag <= FIRST_TAG[TAG_W-1:0];
        else                   rspTag <= nextTag[TAG_W-1:0];
      end
    end
  end

  assert_guest_tag_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspErr) |-> (rspTag != '0) && (rspTag <= maxTag));

  assert_keep_same_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.keep |=> (rspTag == $past(reqTag)) && (rspFlush == FLUSH_NONE) &&
                    (nextTag == $past(nextTag)));

  assert_roll_flush_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFlush == FLUSH_TAG_ALL) |-> (rspTag == FIRST_TAG[TAG_W-1:0]));

  assert_roll_gen_moves_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.roll |=> (curGen != $past(curGen)) && (rspGen == curGen));

  assert_gen_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    curGen != '0);

  assert_err_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspTag == '0) && (rspFlush == FLUSH_NONE));

  assert_flush_codes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspFlush == FLUSH_NONE) || (rspFlush == FLUSH_TAG_ALL));

endmodule

// File: rtl/guest_tag_alloc.sv
module guest_tag_alloc
  import guest_tag_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int GEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W:0]   cfgTagCount,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [GEN_W-1:0] reqGen,
  output logic             rspValid,
  output logic [TAG_W-1:0] rspTag,
  output logic [GEN_W-1:0] rspGen,
  output logic [2:0]       rspFlush,
  output logic             rspErr
);

  alloc_strobe_t    strobe;
  logic [TAG_W-1:0] maxTag;
  logic [TAG_W:0]   nextTag;
  logic [GEN_W-1:0] curGen;
  flush_e           flushCode;

  guest_tag_ctrl #(.TAG_W(TAG_W), .GEN_W(GEN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqTag   (reqTag),
    .reqGen   (reqGen),
    .maxTag   (maxTag),
    .nextTag  (nextTag),
    .curGen   (curGen),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  guest_tag_dp #(.TAG_W(TAG_W), .GEN_W(GEN_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgTagCount (cfgTagCount),
    .reqTag      (reqTag),
    .strobe      (strobe),
    .maxTag      (maxTag),
    .nextTag     (nextTag),
    .curGen      (curGen),
    .rspValid    (rspValid),
    .rspTag      (rspTag),
    .rspGen      (rspGen),
    .rspFlush    (flushCode),
    .rspErr      (rspErr)
  );

  assign rspFlush = flushCode;

  assert_answer_next_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

endmodule

// File: tb/guest_tag_alloc_tb_top.sv
module guest_tag_alloc_tb_top;

  localparam int TAG_W = 8;
  localparam int GEN_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [TAG_W:0]   cfgTagCount = '0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [TAG_W-1:0] reqTag = '0;
  logic [GEN_W-1:0] reqGen = '0;
  logic             rspValid;
  logic [TAG_W-1:0] rspTag;
  logic [GEN_W-1:0] rspGen;
  logic [2:0]       rspFlush;
  logic             rspErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  guest_tag_alloc #(.TAG_W(TAG_W), .GEN_W(GEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgTagCount(cfgTagCount),
    .reqValid(reqValid), .reqReady(reqReady), .reqTag(reqTag), .reqGen(reqGen),
    .rspValid(rspValid), .rspTag(rspTag), .rspGen(rspGen),
    .rspFlush(rspFlush), .rspErr(rspErr)
  );

  // vector: reqTag, reqGen, expTag, expGen, expFlush, expErr (count = 4)
  localparam logic [47:0] VEC [0:11] = '{
    {8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0},
    {8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0},
    {8'd0, 8'd0, 8'd2, 8'd1, 8'd0, 8'd0},
    {8'd0, 8'd1, 8'd3, 8'd1, 8'd0, 8'd0},
    {8'd2, 8'd1, 8'd2, 8'd1, 8'd0, 8'd0},
    {8'd3, 8'd1, 8'd3, 8'd1, 8'd0, 8'd0},
    {8'd1, 8'd0, 8'd1, 8'd2, 8'd1, 8'd0},
    {8'd3, 8'd1, 8'd2, 8'd2, 8'd0, 8'd0},
    {8'd1, 8'd2, 8'd1, 8'd2, 8'd0, 8'd0},
    {8'd5, 8'd2, 8'd3, 8'd2, 8'd0, 8'd0},
    {8'd3, 8'd2, 8'd3, 8'd2, 8'd0, 8'd0},
    {8'd2, 8'd1, 8'd1, 8'd3, 8'd1, 8'd0}
  };

  function automatic logic [31:0] pack(input logic v, input logic [7:0] t,
                                       input logic [7:0] g, input logic [2:0] f,
                                       input logic e);
    return {11'd0, v, e, f, g, t};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic resetWith(input logic [TAG_W:0] count);
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    cfgTagCount = count;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b0, "R8 ready low in reset", {31'd0, reqReady}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && rspValid == 1'b0, "R8 ready after reset",
        {30'd0, reqReady, rspValid}, 32'd2);
  endtask

  // drive at a falling edge, sample the registered answer one cycle later
  task automatic doReq(input logic [7:0] t, input logic [7:0] g,
                       input logic [7:0] et, input logic [7:0] eg,
                       input logic [2:0] ef, input logic ee, input string req);
    logic [31:0] act, exp;
    reqValid = 1'b1;
    reqTag = t;
    reqGen = g;
    @(negedge clk);
    reqValid = 1'b0;
    act = pack(rspValid, rspTag, rspGen, rspFlush, rspErr);
    exp = pack(1'b1, et, eg, ef, ee);
    chk(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // table: R1 R3 R4 R5 with four tags (largest tag 3)
    resetWith(9'd4);
    for (int i = 0; i < 12; i++) begin
      doReq(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16],
            VEC[i][10:8], VEC[i][0], "R3/R4/R5 vector table");
    end

    // R8: idle cycle gives no response
    @(negedge clk);
    chk(rspValid == 1'b0, "R8 idle no response", {31'd0, rspValid}, 32'd0);

    // R7: counts 1 and 0 leave no guest tags
    resetWith(9'd1);
    doReq(8'd0, 8'd0, 8'd0, 8'd1, 3'd0, 1'b1, "R7 count one error");
    doReq(8'd1, 8'd1, 8'd0, 8'd1, 3'd0, 1'b1, "R7 count one repeated");
    resetWith(9'd0);
    doReq(8'd0, 8'd0, 8'd0, 8'd1, 3'd0, 1'b1, "R7 count zero error");

    // R2 clamp: count 300 gives largest tag 255; R4 issue order
    resetWith(9'd300);
    for (int i = 1; i < 256; i++) begin
      doReq(8'd0, 8'd0, 8'(i), 8'd1, 3'd0, 1'b0, "R2 R4 sweep of all tags");
    end
    doReq(8'd0, 8'd0, 8'd1, 8'd2, 3'd1, 1'b0, "R5 rollover after tag 255");
    doReq(8'd255, 8'd2, 8'd255, 8'd2, 3'd0, 1'b0, "R2 R3 keep top tag");
    doReq(8'd0, 8'd0, 8'd2, 8'd2, 3'd0, 1'b0, "R5 second tag after roll");

    // R6 generation wrap with a single guest tag
    resetWith(9'd2);
    doReq(8'd0, 8'd0, 8'd1, 8'd1, 3'd0, 1'b0, "R6 first tag generation one");
    for (int k = 2; k < 256; k++) begin
      doReq(8'd0, 8'd0, 8'd1, 8'(k), 3'd1, 1'b0, "R5 R6 rolling generation");
    end
    doReq(8'd0, 8'd0, 8'd1, 8'd1, 3'd1, 1'b0, "R6 wrap skips zero");
    doReq(8'd1, 8'd1, 8'd1, 8'd1, 3'd0, 1'b0, "R3 R9 keep after wrap");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule